// File: doc/BRIEF.md
# Message-Signaled Interrupt Delivery Engine

This block samples a bank of interrupt lines and converts each interrupt event into one memory-write message sent upstream. Every line is individually set to edge or level behaviour, can be masked, and owns a programmable 8-bit vector. Pending work is kept in a per-line request register. A small state machine takes the lowest-numbered eligible request, asks for the upstream bus, waits for the grant, and then drives a single write. That write carries a fixed address and a data word whose low byte is the vector.

Level-sensitive lines move into an in-service state once their message is sent. They stay there until an end-of-interrupt (EOI) arrives that carries their vector. If the line is still active at that point, a new request is raised at once. Devices can also post an interrupt by writing a line index to the pin-assertion register at offset 0x20 of the register port. Messages go out only while both the global enable and the delivery-type bit are set.

The state machine has three states. IDLE moves to WAIT_GNT when some request is eligible (the "pick" transition, which latches the index). WAIT_GNT holds bus_req high and moves to SEND when bus_gnt is seen (the "granted" transition). SEND drives msg_valid for exactly one cycle, clears the request, and always returns to IDLE (the "done" transition).

Top module: `msi_engine`

## Requirements
- R1: An edge-mode line (mode bit 0) produces exactly one message per low-to-high transition. Holding it high produces no further message.
- R2: A level-mode line (mode bit 1) produces one message on its rising transition. No second message is sent for that line before a matching EOI, even while it stays high.
- R3: An EOI whose vector equals a level line's vector, while that line is in service, ends the in-service state. If the line is still high, exactly one new message follows. If the line is low, or the EOI vector differs, no message follows.
- R4: A level-mode line that falls before its message is issued has its request bit (register 0x10, bit = line index) cleared, and no message is sent for it.
- R5: bus_req is held high while a message waits. msg_valid is asserted only in the cycle after a cycle with bus_req and bus_gnt both high. With bus_gnt low, no message is issued.
- R6: Messages are issued only while CTRL (0x00) bit 0 (enable) and bit 1 (delivery type) are both 1. Requests raised while either bit is 0 stay pending in register 0x10 and are delivered once both bits are set.
- R7: CAP register 0x04 bit 0 reads 0 unless CTRL bit 2 (extended mode) is 1, and reads 1 when it is.
- R8: A write to offset 0x20 with a value below 24 is an edge event on the line with that index. A value of 24 or more has no effect.
- R9: Among several pending requests, the lowest line index is sent first. Only one message is in flight at a time, and msg_valid lasts one cycle.
- R10: Every message has address 0xFEE00000 and data whose bits 7:0 are the vector of the line, written at 0x40 + 4*index, with all higher bits 0.
- R11: A line whose MASK bit (register 0x0C) is 1 sends no message, but its request stays pending and is sent once the mask bit is cleared.
- R12: After reset, bus_req and msg_valid are 0 and CTRL and the request register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 24 | Interrupt lines, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| bus_req | output | 1 | Upstream bus request |
| bus_gnt | input | 1 | Upstream bus grant |
| msg_valid | output | 1 | Message write cycle |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The stimulus table drives single lines in both modes at the low, middle and top indices with distinct vectors. A wrong index-to-vector mapping, a repeat while a line is held high, or a message after a late EOI each shows up as a wrong message count or a wrong data byte. Directed patterns then separate the rest. Simultaneous rises on three lines reveal the service order. A matching and a non-matching EOI on a line that is still high show whether re-signalling is tied to the vector. A line that drops while delivery is disabled shows whether a level request is withdrawn. Holding the grant low shows whether the write waits for the bus.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_SEND
    } msi_state_e;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CAP  = 8'h04;
    localparam logic [7:0] OFS_MODE = 8'h08;
    localparam logic [7:0] OFS_MASK = 8'h0C;
    localparam logic [7:0] OFS_PEND = 8'h10;
    localparam logic [7:0] OFS_PIN  = 8'h20;
    localparam logic [7:0] OFS_VEC  = 8'h40;

    localparam int CTL_EN = 0;
    localparam int CTL_DT = 1;
    localparam int CTL_XM = 2;
endpackage

// File: rtl/msi_regs.sv
module msi_regs
    import msi_pkg::*;
#(
    parameter int N_IRQ = 24,
    parameter int VEC_W = 8,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    input  logic [N_IRQ-1:0]       pend_view,
    output logic                   mode_on,
    output logic [N_IRQ-1:0]       level_sel,
    output logic [N_IRQ-1:0]       mask,
    output logic [N_IRQ*VEC_W-1:0] vec_flat,
    output logic                   pin_hit,
    output logic [IDX_W-1:0]       pin_idx
);
    logic [2:0]       ctrl_q;
    logic [VEC_W-1:0] vec_q [N_IRQ];
    logic [AW-1:0]    vofs;
    logic [AW-1:0]    vsel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            level_sel <= '0;
            mask      <= '0;
        end else if (we) begin
            if (addr == AW'(OFS_CTRL)) ctrl_q    <= wdata[2:0];
            if (addr == AW'(OFS_MODE)) level_sel <= wdata[N_IRQ-1:0];
            if (addr == AW'(OFS_MASK)) mask      <= wdata[N_IRQ-1:0];
        end
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_vec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vec_q[i] <= '0;
            else if (we && addr == AW'(OFS_VEC + 4 * i))
                vec_q[i] <= wdata[VEC_W-1:0];
        end
        assign vec_flat[i*VEC_W +: VEC_W] = vec_q[i];
    end

    assign mode_on = ctrl_q[CTL_EN] & ctrl_q[CTL_DT];
    assign pin_hit = we && (addr == AW'(OFS_PIN)) && (wdata < DW'(N_IRQ));
    assign pin_idx = wdata[IDX_W-1:0];
    assign vofs    = addr - AW'(OFS_VEC);
    assign vsel    = vofs >> 2;

    always_comb begin
        rdata = '0;
        unique case (addr)
            AW'(OFS_CTRL): rdata[2:0]       = ctrl_q;
            AW'(OFS_CAP):  rdata[0]         = ctrl_q[CTL_XM];
            AW'(OFS_MODE): rdata[N_IRQ-1:0] = level_sel;
            AW'(OFS_MASK): rdata[N_IRQ-1:0] = mask;
            AW'(OFS_PEND): rdata[N_IRQ-1:0] = pend_view;
            default: begin
                if (addr >= AW'(OFS_VEC) && vsel < AW'(N_IRQ) && vofs[1:0] == 2'b00)
                    rdata[VEC_W-1:0] = vec_q[vsel[IDX_W-1:0]];
            end
        endcase
    end
endmodule

// File: rtl/msi_detect.sv
module msi_detect #(
    parameter int N_IRQ = 24,
    parameter int VEC_W = 8,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IRQ-1:0]       irq_in,
    input  logic [N_IRQ-1:0]       level_sel,
    input  logic [N_IRQ*VEC_W-1:0] vec_flat,
    input  logic                   pin_hit,
    input  logic [IDX_W-1:0]       pin_idx,
    input  logic                   eoi_valid,
    input  logic [VEC_W-1:0]       eoi_vector,
    input  logic                   sent,
    input  logic [IDX_W-1:0]       sent_idx,
    output logic [N_IRQ-1:0]       pend,
    output logic [N_IRQ-1:0]       in_svc
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        logic irq_q, p_q, s_q;
        logic rise, fall, pin_ev, sent_me, eoi_me;

        assign rise    = irq_in[i] & ~irq_q;
        assign fall    = ~irq_in[i] & irq_q;
        assign pin_ev  = pin_hit && (pin_idx == IDX_W'(i));
        assign sent_me = sent && (sent_idx == IDX_W'(i));
        assign eoi_me  = eoi_valid && s_q && (vec_flat[i*VEC_W +: VEC_W] == eoi_vector);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_q <= 1'b0;
                p_q   <= 1'b0;
                s_q   <= 1'b0;
            end else begin
                irq_q <= irq_in[i];
                if (level_sel[i]) begin
                    if (sent_me) begin
                        p_q <= 1'b0;
                        s_q <= 1'b1;
                    end else if (eoi_me) begin
                        s_q <= 1'b0;
                        p_q <= irq_in[i];
                    end else if ((rise || pin_ev) && !s_q) begin
                        p_q <= 1'b1;
                    end else if (fall) begin
                        p_q <= 1'b0;
                    end
                end else begin
                    s_q <= 1'b0;
                    if (rise || pin_ev) p_q <= 1'b1;
                    else if (sent_me)   p_q <= 1'b0;
                end
            end
        end

        assign pend[i]   = p_q;
        assign in_svc[i] = s_q;
    end

    // A line in service never carries a second request before its EOI
    assert_no_double_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & in_svc) == '0);
endmodule

// File: rtl/msi_arb.sv
module msi_arb #(
    parameter int N_IRQ = 24,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] elig,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/msi_engine.sv
module msi_engine
    import msi_pkg::*;
#(
    parameter int          N_IRQ    = 24,
    parameter int          VEC_W    = 8,
    parameter int          AW       = 8,
    parameter int          DW       = 32,
    parameter logic [31:0] MSG_ADDR = 32'hFEE0_0000,
    localparam int IDX_W = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             msg_valid,
    output logic [31:0]      msg_addr,
    output logic [DW-1:0]    msg_data
);
    msi_state_e             state_q, state_d;
    logic [IDX_W-1:0]       idx_q;
    logic                   mode_on, pin_hit, any;
    logic [IDX_W-1:0]       pin_idx, pick;
    logic [N_IRQ-1:0]       level_sel, mask, pend, in_svc, elig;
    logic [N_IRQ*VEC_W-1:0] vec_flat;
    logic [VEC_W-1:0]       vec_sel;

    msi_regs #(.N_IRQ(N_IRQ), .VEC_W(VEC_W), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .pend_view(pend),
        .mode_on(mode_on), .level_sel(level_sel), .mask(mask),
        .vec_flat(vec_flat), .pin_hit(pin_hit), .pin_idx(pin_idx)
    );

    msi_detect #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_det (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_sel),
        .vec_flat(vec_flat), .pin_hit(pin_hit), .pin_idx(pin_idx),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .sent(msg_valid), .sent_idx(idx_q), .pend(pend), .in_svc(in_svc)
    );

    assign elig = pend & ~mask & {N_IRQ{mode_on}};

    msi_arb #(.N_IRQ(N_IRQ)) u_arb (.elig(elig), .any(any), .idx(pick));

    // State register and latched index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any) idx_q <= pick;
        end
    end

    // Transitions: pick, granted, done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (any) state_d = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt) state_d = ST_SEND;
            ST_SEND:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign vec_sel = vec_flat[idx_q*VEC_W +: VEC_W];

    // Outputs from state
    always_comb begin
        bus_req   = (state_q == ST_WAIT_GNT);
        msg_valid = (state_q == ST_SEND);
        msg_addr  = msg_valid ? MSG_ADDR : '0;
        msg_data  = msg_valid ? DW'(vec_sel) : '0;
    end

    assert_grant_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(bus_req && bus_gnt));

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    assert_mode_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(mode_on));

    assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);
endmodule

// File: tb/sim_msi_engine.sv
module sim_msi_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_in = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        bus_req;
    logic        bus_gnt = 1'b1;
    logic        msg_valid;
    logic [31:0] msg_addr, msg_data;

    int tests = 0, fails = 0, msg_cnt = 0, bad_order = 0;
    logic [31:0] last_data = '0, last_addr = '0;
    logic [31:0] log_d [8];
    logic prev_rg = 1'b0;
    bit done = 1'b0;

    // {index[13:9], level[8], vector[7:0]}
    localparam logic [13:0] TBL [6] = '{
        {5'd0,  1'b0, 8'h31},
        {5'd5,  1'b1, 8'h42},
        {5'd23, 1'b0, 8'h99},
        {5'd12, 1'b1, 8'hA0},
        {5'd7,  1'b0, 8'hFF},
        {5'd17, 1'b1, 8'h01}
    };

    msi_engine u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (msg_valid) begin
            if (!prev_rg) bad_order++;
            log_d[msg_cnt & 7] = msg_data;
            last_data = msg_data;
            last_addr = msg_addr;
            msg_cnt++;
        end
        prev_rg = bus_req && bus_gnt;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got %h expected %h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int c0;
        settle(2);
        rst_n = 1'b1;
        settle(1);

        // R12 reset state
        chk(bus_req == 0 && msg_valid == 0, "R12 outputs", {bus_req, msg_valid}, 0);
        rd(8'h00, r); chk(r == 0, "R12 ctrl", r, 0);
        rd(8'h10, r); chk(r == 0, "R12 pend", r, 0);

        // R7 capability bit
        wr(8'h00, 32'h3);
        rd(8'h04, r); chk(r[0] == 0, "R7 cap off", r, 0);
        wr(8'h00, 32'h7);
        rd(8'h04, r); chk(r[0] == 1, "R7 cap on", r, 1);

        // Table: R1, R2, R10
        for (int k = 0; k < 6; k++) begin
            logic [4:0] ix;
            logic       lv;
            logic [7:0] v;
            ix = TBL[k][13:9]; lv = TBL[k][8]; v = TBL[k][7:0];
            wr(8'(8'h40 + 4 * ix), {24'h0, v});
            wr(8'h08, lv ? (32'h1 << ix) : 32'h0);
            c0 = msg_cnt;
            irq_in[ix] = 1'b1;
            settle(8);
            chk(msg_cnt == c0 + 1, lv ? "R2 first msg" : "R1 first msg", msg_cnt, c0 + 1);
            chk(last_data == {24'h0, v}, "R10 data", last_data, {24'h0, v});
            chk(last_addr == 32'hFEE0_0000, "R10 addr", last_addr, 32'hFEE0_0000);
            settle(8);
            chk(msg_cnt == c0 + 1, lv ? "R2 held high" : "R1 held high", msg_cnt, c0 + 1);
            irq_in[ix] = 1'b0;
            settle(2);
            if (lv) eoi(v);
            settle(8);
            chk(msg_cnt == c0 + 1, "R3 low at EOI", msg_cnt, c0 + 1);
        end

        // R3 re-signal after matching EOI
        wr(8'h4C, 32'h55);
        wr(8'h08, 32'h1 << 3);
        c0 = msg_cnt;
        irq_in[3] = 1'b1;
        settle(8);
        chk(msg_cnt == c0 + 1, "R3 first", msg_cnt, c0 + 1);
        eoi(8'h56);
        settle(8);
        chk(msg_cnt == c0 + 1, "R3 wrong vector", msg_cnt, c0 + 1);
        eoi(8'h55);
        settle(8);
        chk(msg_cnt == c0 + 2, "R3 resend", msg_cnt, c0 + 2);
        chk(last_data == 32'h55, "R3 resend data", last_data, 32'h55);
        irq_in[3] = 1'b0;
        settle(2);
        eoi(8'h55);
        settle(8);
        chk(msg_cnt == c0 + 2, "R3 no resend when low", msg_cnt, c0 + 2);

        // R4 level drop withdraws request
        wr(8'h00, 32'h4);
        wr(8'h08, 32'h1 << 9);
        irq_in[9] = 1'b1;
        settle(2);
        rd(8'h10, r); chk(r[9] == 1, "R4 pending", r, 32'h200);
        irq_in[9] = 1'b0;
        settle(2);
        rd(8'h10, r); chk(r[9] == 0, "R4 withdrawn", r, 0);
        c0 = msg_cnt;
        wr(8'h00, 32'h7);
        settle(8);
        chk(msg_cnt == c0, "R4 no message", msg_cnt, c0);
        wr(8'h08, 32'h0);

        // R6 both enables needed
        wr(8'h68, 32'h6A);
        wr(8'h00, 32'h5);
        c0 = msg_cnt;
        irq_in[10] = 1'b1;
        settle(6);
        chk(msg_cnt == c0, "R6 dt off", msg_cnt, c0);
        rd(8'h10, r); chk(r[10] == 1, "R6 kept pending", r, 32'h400);
        wr(8'h00, 32'h6);
        settle(6);
        chk(msg_cnt == c0, "R6 en off", msg_cnt, c0);
        wr(8'h00, 32'h7);
        settle(8);
        chk(msg_cnt == c0 + 1 && last_data == 32'h6A, "R6 delivered", last_data, 32'h6A);
        irq_in[10] = 1'b0;

        // R11 mask
        wr(8'h48, 32'h22);
        wr(8'h0C, 32'h1 << 2);
        c0 = msg_cnt;
        irq_in[2] = 1'b1;
        settle(8);
        chk(msg_cnt == c0, "R11 masked", msg_cnt, c0);
        rd(8'h10, r); chk(r[2] == 1, "R11 pending", r, 32'h4);
        wr(8'h0C, 32'h0);
        settle(8);
        chk(msg_cnt == c0 + 1 && last_data == 32'h22, "R11 unmasked", last_data, 32'h22);
        irq_in[2] = 1'b0;

        // R9 priority order
        wr(8'h50, 32'h14);
        wr(8'h7C, 32'h1F);
        wr(8'h90, 32'h24);
        wr(8'h00, 32'h4);
        irq_in[20] = 1'b1; irq_in[4] = 1'b1; irq_in[15] = 1'b1;
        settle(3);
        c0 = msg_cnt;
        wr(8'h00, 32'h7);
        settle(20);
        chk(msg_cnt == c0 + 3, "R9 count", msg_cnt, c0 + 3);
        chk(log_d[(c0) & 7] == 32'h14, "R9 first", log_d[(c0) & 7], 32'h14);
        chk(log_d[(c0 + 1) & 7] == 32'h1F, "R9 second", log_d[(c0 + 1) & 7], 32'h1F);
        chk(log_d[(c0 + 2) & 7] == 32'h24, "R9 third", log_d[(c0 + 2) & 7], 32'h24);
        irq_in = '0;

        // R8 pin-assertion register
        wr(8'h78, 32'hE4);
        c0 = msg_cnt;
        wr(8'h20, 32'd14);
        settle(8);
        chk(msg_cnt == c0 + 1 && last_data == 32'hE4, "R8 write event", last_data, 32'hE4);
        wr(8'h20, 32'd30);
        settle(8);
        chk(msg_cnt == c0 + 1, "R8 out of range", msg_cnt, c0 + 1);

        // R5 grant handshake
        wr(8'h44, 32'h11);
        bus_gnt = 1'b0;
        c0 = msg_cnt;
        irq_in[1] = 1'b1;
        settle(6);
        chk(bus_req == 1, "R5 request held", bus_req, 1);
        chk(msg_cnt == c0, "R5 no msg without grant", msg_cnt, c0);
        bus_gnt = 1'b1;
        settle(4);
        chk(msg_cnt == c0 + 1 && last_data == 32'h11, "R5 after grant", last_data, 32'h11);
        chk(bad_order == 0, "R5 order", bad_order, 0);
        irq_in[1] = 1'b0;
        settle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule